// File: doc/BRIEF.md
# Refresh-Aware Command Gate

This block sits beside a DRAM command timing checker. It works out when the next refresh will be due and when the precharge that must come before it has to happen. When a command is offered with a candidate start cycle, the block checks whether that command would still be busy at the precharge point. If it would, the block moves the start to the cycle when the refresh has finished (refresh cycle plus tRFC). Otherwise it returns the candidate unchanged. The result is combinational, so the timing checker can fold it into its maximum in the same cycle.

Each time the controller issues a refresh, it pulses a strobe, and the block moves its deadlines forward by one refresh interval. A parameter fixes the mode, with three choices:
- Off: the gate passes every command through.
- All-bank: one shared schedule for all banks.
- Per-bank: each bank has its own schedule, staggered by one clock per bank.

The block does not issue refreshes or precharges.

Top module: `refresh_cmd_gate`

## Requirements
- R1: In all-bank mode (GATE_MODE=1), reset sets the refresh deadline to T_REFI and the precharge deadline to T_REFI-T_RP, both in the counter time base.
- R2: Command codes are 0=activate, 1=read, 2=write, 3=precharge. An activate is deferred when cand_start + T_RAS >= precharge deadline, and the test is computed one bit wider than the counter so it never wraps. A deferred command gets adj_start = refresh deadline + T_RFC. Any command that is not deferred gets adj_start = cand_start.
- R3: A read is deferred when cand_start + T_RTP >= precharge deadline.
- R4: A write is deferred when cand_start + T_WL + BURST_LEN/2 + T_WR >= precharge deadline.
- R5: In all-bank mode, a precharge is deferred when cand_start >= precharge deadline.
- R6: Each cycle with ref_ins high moves both deadlines of the schedule forward by T_REFI at the next clock edge. Without the strobe, the deadlines do not change.
- R7: In per-bank mode (GATE_MODE=2) with N banks, bank i starts with refresh deadline T_REFI-(N-1)+i and precharge deadline equal to that value minus max(N, T_RP). Activate, read and write use the thresholds of R2 to R4 against the deadlines of the bank in cmd_bank.
- R8: In per-bank mode, a refresh strobe moves only the deadlines of the bank in ref_bank forward.
- R9: In per-bank mode, a precharge is never deferred.
- R10: In off mode (GATE_MODE=0), adj_start always equals cand_start, and refresh strobes have no effect.
- R11: adj_start follows the command inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_kind | input | 2 | Command code: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BW | Target bank of the command (per-bank mode) |
| cand_start | input | TW | Candidate earliest start cycle |
| ref_ins | input | 1 | Refresh-issued strobe |
| ref_bank | input | BW | Bank that was refreshed (per-bank mode) |
| adj_start | output | TW | Adjusted earliest start cycle |

## Verification
The bench builds three copies of the block, one for each mode. All three use a 16-bit counter, four banks, T_REFI=100, T_RP=5, T_RAS=10, T_RTP=3, T_WL=4, burst length 8, T_WR=6 and T_RFC=20. With such a short interval, every threshold lands within a few cycles of a deadline. The table can therefore probe each command type one cycle below and exactly at its threshold, and can check each bank's stagger against the hand-computed deadlines 97..100 and 92..95. A few strobes then show the deadlines advancing by one interval, confined to a single bank in per-bank mode. A final reset shows that the starting schedule comes back.

// File: rtl/refgate_pkg.sv
package refgate_pkg;
   typedef enum logic [1:0] {
      CMD_ACT = 2'd0,
      CMD_RD  = 2'd1,
      CMD_WR  = 2'd2,
      CMD_PRE = 2'd3
   } cmd_e;

   localparam int GATE_OFF     = 0;
   localparam int GATE_ALLBANK = 1;
   localparam int GATE_PERBANK = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/refgate_sched.sv
// One refresh schedule: a refresh deadline and the precharge deadline before it.
module refgate_sched #(
   parameter int TW       = 32,
   parameter int INIT_REF = 100,
   parameter int INIT_PRE = 90,
   parameter int T_REFI   = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [TW-1:0] ref_dl,
   output logic [TW-1:0] pre_dl
);
   localparam logic [TW-1:0] STEP = TW'(T_REFI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_dl <= TW'(INIT_REF);
         pre_dl <= TW'(INIT_PRE);
      end else if (adv) begin
         ref_dl <= ref_dl + STEP;
         pre_dl <= pre_dl + STEP;
      end
   end
endmodule

// File: rtl/refgate_slack.sv
// Decides whether a command would still be busy at the precharge deadline.
module refgate_slack
   import refgate_pkg::*;
#(
   parameter int TW        = 32,
   parameter int T_RAS     = 32,
   parameter int T_RTP     = 8,
   parameter int T_WL      = 12,
   parameter int BURST_LEN = 8,
   parameter int T_WR      = 16,
   parameter bit GATE_PRE  = 1'b1
) (
   input  logic [1:0]    cmd,
   input  logic [TW-1:0] cand,
   input  logic [TW-1:0] pre_dl,
   output logic          hit
);
   localparam int OFF_WR = T_WL + BURST_LEN / 2 + T_WR;

   logic [TW:0] span;
   logic        gated;

   always_comb begin
      gated = 1'b1;
      unique case (cmd)
         CMD_ACT: span = (TW+1)'(T_RAS);
         CMD_RD:  span = (TW+1)'(T_RTP);
         CMD_WR:  span = (TW+1)'(OFF_WR);
         default: begin
            span  = '0;
            gated = GATE_PRE;
         end
      endcase
      hit = gated && (({1'b0, cand} + span) >= {1'b0, pre_dl});
   end
endmodule

// File: rtl/refresh_cmd_gate.sv
module refresh_cmd_gate
   import refgate_pkg::*;
#(
   parameter int GATE_MODE = GATE_ALLBANK,
   parameter int TW        = 32,
   parameter int NBANK     = 16,
   parameter int T_REFI    = 7800,
   parameter int T_RFC     = 350,
   parameter int T_RP      = 14,
   parameter int T_RAS     = 32,
   parameter int T_RTP     = 8,
   parameter int T_WL      = 12,
   parameter int BURST_LEN = 8,
   parameter int T_WR      = 16,
   localparam int BW       = $clog2(NBANK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cmd_kind,
   input  logic [BW-1:0] cmd_bank,
   input  logic [TW-1:0] cand_start,
   input  logic          ref_ins,
   input  logic [BW-1:0] ref_bank,
   output logic [TW-1:0] adj_start
);
   localparam int PB_LEAD  = imax(NBANK, T_RP);
   localparam int PB_FIRST = T_REFI - (NBANK - 1);

   // elaboration-time parameter checks
   if (GATE_MODE < GATE_OFF || GATE_MODE > GATE_PERBANK) begin : g_bad_mode
      $error("refresh_cmd_gate: GATE_MODE out of range");
   end
   if (TW < 8 || TW > 32) begin : g_bad_tw
      $error("refresh_cmd_gate: TW must lie in 8..32");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
      $error("refresh_cmd_gate: NBANK must be a power of two, at least 2");
   end
   if (T_REFI <= (NBANK - 1) + PB_LEAD || T_REFI <= T_RP) begin : g_bad_refi
      $error("refresh_cmd_gate: T_REFI too short for the stagger");
   end

   logic [TW-1:0] sel_ref;
   logic [TW-1:0] sel_pre;
   logic          defer;

   logic unused_inputs;
   assign unused_inputs = ^{clk, rst_n, ref_ins, ref_bank, cmd_bank};

   if (GATE_MODE == GATE_OFF) begin : g_off
      assign sel_ref = '0;
      assign sel_pre = '0;
      assign defer   = 1'b0;
   end else if (GATE_MODE == GATE_ALLBANK) begin : g_all
      refgate_sched #(
         .TW(TW), .INIT_REF(T_REFI), .INIT_PRE(T_REFI - T_RP), .T_REFI(T_REFI)
      ) u_sched (
         .clk(clk), .rst_n(rst_n), .adv(ref_ins),
         .ref_dl(sel_ref), .pre_dl(sel_pre)
      );
      refgate_slack #(
         .TW(TW), .T_RAS(T_RAS), .T_RTP(T_RTP), .T_WL(T_WL),
         .BURST_LEN(BURST_LEN), .T_WR(T_WR), .GATE_PRE(1'b1)
      ) u_slack (
         .cmd(cmd_kind), .cand(cand_start), .pre_dl(sel_pre), .hit(defer)
      );
   end else begin : g_per
      logic [TW-1:0] ref_arr [NBANK];
      logic [TW-1:0] pre_arr [NBANK];
      for (genvar i = 0; i < NBANK; i++) begin : g_bank
         refgate_sched #(
            .TW(TW), .INIT_REF(PB_FIRST + i), .INIT_PRE(PB_FIRST + i - PB_LEAD),
            .T_REFI(T_REFI)
         ) u_sched (
            .clk(clk), .rst_n(rst_n),
            .adv(ref_ins && (ref_bank == BW'(i))),
            .ref_dl(ref_arr[i]), .pre_dl(pre_arr[i])
         );
      end
      assign sel_ref = ref_arr[cmd_bank];
      assign sel_pre = pre_arr[cmd_bank];
      refgate_slack #(
         .TW(TW), .T_RAS(T_RAS), .T_RTP(T_RTP), .T_WL(T_WL),
         .BURST_LEN(BURST_LEN), .T_WR(T_WR), .GATE_PRE(1'b0)
      ) u_slack (
         .cmd(cmd_kind), .cand(cand_start), .pre_dl(sel_pre), .hit(defer)
      );
   end

   // R11: combinational result, no register in the path
   assign adj_start = defer ? (sel_ref + TW'(T_RFC)) : cand_start;
endmodule

// File: rtl/refgate_chk.sv
module refgate_chk #(
   parameter int GATE_MODE = 1,
   parameter int TW        = 32,
   parameter int T_REFI    = 7800,
   parameter int T_RFC     = 350,
   parameter int T_RP      = 14,
   parameter int T_RAS     = 32,
   parameter int T_RTP     = 8,
   parameter int T_WL      = 12,
   parameter int BURST_LEN = 8,
   parameter int T_WR      = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    cmd_kind,
   input logic [TW-1:0] cand_start,
   input logic          ref_ins,
   input logic [TW-1:0] adj_start,
   input logic [TW-1:0] sel_ref,
   input logic [TW-1:0] sel_pre
);
   function automatic logic [TW:0] busy_span(input logic [1:0] k);
      case (k)
         2'd0:    return (TW+1)'(T_RAS);
         2'd1:    return (TW+1)'(T_RTP);
         2'd2:    return (TW+1)'(T_WL + BURST_LEN / 2 + T_WR);
         default: return '0;
      endcase
   endfunction

   if (GATE_MODE == 0) begin : g_off
      p_off_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
         adj_start == cand_start);
   end else begin : g_on
      p_defer_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (adj_start != cand_start) |-> (adj_start == sel_ref + TW'(T_RFC)));
      p_early_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (({1'b0, cand_start} + busy_span(cmd_kind)) < {1'b0, sel_pre})
         |-> (adj_start == cand_start));
   end

   if (GATE_MODE == 1) begin : g_all
      p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
         sel_ref - sel_pre == TW'(T_RP));
      p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ref_ins |=> sel_ref == $past(sel_ref) + TW'(T_REFI));
      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !ref_ins |=> $stable(sel_ref));
   end

   if (GATE_MODE == 2) begin : g_per
      p_pre_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_kind == 2'd3) |-> (adj_start == cand_start));
   end
endmodule

bind refresh_cmd_gate refgate_chk #(
   .GATE_MODE(GATE_MODE), .TW(TW), .T_REFI(T_REFI), .T_RFC(T_RFC), .T_RP(T_RP),
   .T_RAS(T_RAS), .T_RTP(T_RTP), .T_WL(T_WL), .BURST_LEN(BURST_LEN), .T_WR(T_WR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cand_start(cand_start),
   .ref_ins(ref_ins), .adj_start(adj_start), .sel_ref(sel_ref), .sel_pre(sel_pre)
);

// File: tb/sim_refresh_cmd_gate.sv
module sim_refresh_cmd_gate;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int NB = 4;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd_kind = '0;
   logic [BW-1:0] cmd_bank = '0;
   logic [TW-1:0] cand_start = '0;
   logic [BW-1:0] ref_bank = '0;
   logic          ins0 = 1'b0, ins1 = 1'b0, ins2 = 1'b0;
   logic [TW-1:0] adj0, adj1, adj2;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refresh_cmd_gate #(.GATE_MODE(1), .TW(TW), .NBANK(NB), .T_REFI(100), .T_RFC(20),
      .T_RP(5), .T_RAS(10), .T_RTP(3), .T_WL(4), .BURST_LEN(8), .T_WR(6)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
      .cand_start(cand_start), .ref_ins(ins0), .ref_bank(ref_bank), .adj_start(adj0));
   refresh_cmd_gate #(.GATE_MODE(2), .TW(TW), .NBANK(NB), .T_REFI(100), .T_RFC(20),
      .T_RP(5), .T_RAS(10), .T_RTP(3), .T_WL(4), .BURST_LEN(8), .T_WR(6)) u1 (
      .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
      .cand_start(cand_start), .ref_ins(ins1), .ref_bank(ref_bank), .adj_start(adj1));
   refresh_cmd_gate #(.GATE_MODE(0), .TW(TW), .NBANK(NB), .T_REFI(100), .T_RFC(20),
      .T_RP(5), .T_RAS(10), .T_RTP(3), .T_WL(4), .BURST_LEN(8), .T_WR(6)) u2 (
      .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
      .cand_start(cand_start), .ref_ins(ins2), .ref_bank(ref_bank), .adj_start(adj2));

   // vector: {inst[1:0], cmd[1:0], bank[1:0], cand[15:0], expected[15:0], req[7:0]}
   localparam int NV = 19;
   localparam logic [45:0] VEC [NV] = '{
      {2'd0, 2'd0, 2'd0, 16'd84,  16'd84,  8'd2},  // R2 ACT below threshold 85
      {2'd0, 2'd0, 2'd0, 16'd85,  16'd120, 8'd2},  // R2 ACT at threshold
      {2'd0, 2'd1, 2'd0, 16'd91,  16'd91,  8'd3},  // R3 RD threshold 92
      {2'd0, 2'd1, 2'd0, 16'd92,  16'd120, 8'd3},
      {2'd0, 2'd2, 2'd0, 16'd80,  16'd80,  8'd4},  // R4 WR threshold 81
      {2'd0, 2'd2, 2'd0, 16'd81,  16'd120, 8'd4},
      {2'd0, 2'd3, 2'd0, 16'd94,  16'd94,  8'd5},  // R5 PRE threshold 95
      {2'd0, 2'd3, 2'd0, 16'd95,  16'd120, 8'd5},
      {2'd0, 2'd0, 2'd3, 16'd10,  16'd10,  8'd1},  // R1 reset schedule, early command
      {2'd1, 2'd0, 2'd0, 16'd81,  16'd81,  8'd7},  // R7 bank0 pre 92, ref 97
      {2'd1, 2'd0, 2'd0, 16'd82,  16'd117, 8'd7},
      {2'd1, 2'd0, 2'd3, 16'd84,  16'd84,  8'd7},  // R7 bank3 pre 95, ref 100
      {2'd1, 2'd0, 2'd3, 16'd85,  16'd120, 8'd7},
      {2'd1, 2'd1, 2'd1, 16'd89,  16'd89,  8'd7},  // R7 bank1 RD threshold 90
      {2'd1, 2'd1, 2'd1, 16'd90,  16'd118, 8'd7},
      {2'd1, 2'd2, 2'd2, 16'd80,  16'd119, 8'd7},  // R7 bank2 WR threshold 80
      {2'd1, 2'd3, 2'd0, 16'd200, 16'd200, 8'd9},  // R9 PRE never deferred
      {2'd2, 2'd0, 2'd0, 16'd85,  16'd85,  8'd10}, // R10 off mode passes through
      {2'd2, 2'd3, 2'd0, 16'd95,  16'd95,  8'd10}
   };

   function automatic logic [TW-1:0] pick(input int inst);
      case (inst)
         0:       return adj0;
         1:       return adj1;
         default: return adj2;
      endcase
   endfunction

   // drive on the falling edge, sample 1 time unit later (R11: same cycle)
   task automatic probe(input int inst, input logic [1:0] k, input logic [BW-1:0] b,
                        input logic [TW-1:0] c, input logic [TW-1:0] exp, input int req);
      logic [TW-1:0] got;
      @(negedge clk);
      cmd_kind = k; cmd_bank = b; cand_start = c;
      #1;
      got = pick(inst);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d inst %0d cmd %0d bank %0d cand %0d: got %0d expected %0d",
                  req, inst, k, b, c, got, exp);
      end
   endtask

   task automatic pulse(input int inst, input logic [BW-1:0] b);
      @(negedge clk);
      ref_bank = b;
      case (inst)
         0: ins0 = 1'b1;
         1: ins1 = 1'b1;
         default: ins2 = 1'b1;
      endcase
      @(negedge clk);
      ins0 = 1'b0; ins1 = 1'b0; ins2 = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int v = 0; v < NV; v++) begin
         probe(int'(VEC[v][45:44]), VEC[v][43:42], VEC[v][41:40], VEC[v][39:24],
               VEC[v][23:8], int'(VEC[v][7:0]));
      end

      // R6: one all-bank strobe moves refresh to 200 and precharge to 195
      pulse(0, 2'd0);
      probe(0, 2'd0, 2'd0, 16'd85,  16'd85,  6);
      probe(0, 2'd0, 2'd0, 16'd184, 16'd184, 6);
      probe(0, 2'd0, 2'd0, 16'd185, 16'd220, 6);
      probe(0, 2'd3, 2'd0, 16'd195, 16'd220, 6);
      repeat (3) @(negedge clk);  // R6: no strobe, no change
      probe(0, 2'd3, 2'd0, 16'd194, 16'd194, 6);

      // R8: per-bank strobe to bank0 only; bank0 becomes ref 197 pre 192
      pulse(1, 2'd0);
      probe(1, 2'd0, 2'd0, 16'd82,  16'd82,  8);
      probe(1, 2'd0, 2'd0, 16'd182, 16'd217, 8);
      probe(1, 2'd0, 2'd1, 16'd83,  16'd118, 8);  // bank1 untouched

      // R10: strobe in off mode has no effect
      pulse(2, 2'd0);
      probe(2, 2'd0, 2'd0, 16'd5000, 16'd5000, 10);

      // R1: a second reset brings the starting schedule back
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      probe(0, 2'd0, 2'd0, 16'd85, 16'd120, 1);
      probe(1, 2'd0, 2'd0, 16'd82, 16'd117, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule